// File: doc/BRIEF.md
# Machine-Cycle Timer/Counter Unit

This block is a 16-bit up-counter kept as two byte registers. In timer mode it steps once per machine cycle, which is twelve periods of the oscillator clock; the block derives that machine-cycle tick itself from a free-running prescaler. In event mode it counts falling edges on an external pin instead. The pin passes through a synchronizer and is then sampled once per machine cycle, so a level must hold for a full machine cycle to be seen.

Software may load either count byte at any time. When the whole count wraps from all ones back to zero, a sticky overflow flag is raised, and it stays raised until software clears it. A run control freezes the count and discards the edge history. A chip with three timers places three copies of this unit, and each copy supports both modes.

Top module: `mct_timer_unit`

## Requirements
- R1: After synchronous reset, both count bytes are 0x00 and the overflow flag is 0.
- R2: The prescaler runs freely from reset release. A tick falls on the 12th rising edge after release and then on every 12th edge. In timer mode (event_mode = 0) with run_en high, the low byte steps by one on each tick edge.
- R3: When the low byte steps from 0xFF to 0x00, the high byte steps by one on the same edge.
- R4: An increment while the count is 0xFFFF yields 0x0000 and sets ovf_flag. The flag stays set until a cycle with ovf_clr high clears it. If a wrap and ovf_clr fall on the same edge, the flag ends up set.
- R5: In event mode (event_mode = 1), the synchronized pin is sampled on each tick edge. A sample of 1 followed by a sample of 0 on the next tick raises the count by one, one clock edge after the tick that took the 0.
- R6: A pulse that starts and ends between two tick edges is not counted. A pin toggling every 12 clocks gives one count per 24 clocks, which is the highest rate the unit can follow.
- R7: While run_en is low, the count holds and no samples are taken. After run_en rises, the first sample cannot complete an edge, even if the last sample before the pause was 1.
- R8: lo_wr loads wr_data into the low byte on the next edge, and hi_wr does the same for the high byte; the two are independent. When a write lands on the same edge as an increment, the written byte takes the written value, while the other byte still steps (including a carry).
- R9: In timer mode the count ignores the pin. In event mode the count ignores ticks while the pin stays steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Count enable; low freezes the count and clears the edge history |
| event_mode | input | 1 | 0 = timer (count ticks), 1 = event (count falling pin edges) |
| event_pin | input | 1 | External event input, asynchronous |
| lo_wr | input | 1 | Load wr_data into the low count byte |
| hi_wr | input | 1 | Load wr_data into the high count byte |
| wr_data | input | 8 | Write data for the byte loads |
| ovf_clr | input | 1 | Clear the overflow flag |
| count_lo | output | 8 | Low count byte |
| count_hi | output | 8 | High count byte |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions take for granted that the write and clear strobes are synchronous single-cycle inputs. They also assume that run_en and event_mode change only between clock edges, and that event_pin, although asynchronous, is seen by the logic only after the synchronizer. The stimulus drives every input on the falling clock edge. It changes the mode only while run_en is low, and it holds pin levels for whole machine cycles, except in the one case meant to show that a short pulse is missed. Writes aimed at an increment are placed on the clock just before a tick edge, so that the collision is certain.

// File: rtl/mct_pkg.sv
package mct_pkg;

  typedef enum logic {
    MODE_TIMER = 1'b0,
    MODE_EVENT = 1'b1
  } cnt_mode_e;

  localparam int DEFAULT_DIV   = 12;
  localparam int DEFAULT_BYTE  = 8;
  localparam int DEFAULT_SYNC  = 2;

endpackage

// File: rtl/mct_tick_gen.sv
module mct_tick_gen #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 2);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre  <= '0;
      tick <= 1'b0;
    end else begin
      if (pre == LAST) pre <= '0;
      else             pre <= pre + PW'(1);
      tick <= (pre == PRE_LAST);
    end
  end

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R2
  tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (pre == PW'(0)));

endmodule

// File: rtl/mct_fall_detect.sv
module mct_fall_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic pin_s;
  logic cur;
  logic cur_v;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign pin_s = pin;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) begin
          sh <= '0;
        end else begin
          sh[0] <= pin;
          for (int i = 1; i < SYNC_STAGES; i++) sh[i] <= sh[i-1];
        end
      end
      assign pin_s = sh[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= 1'b0;
      cur_v <= 1'b0;
      fall  <= 1'b0;
    end else begin
      fall <= 1'b0;
      if (!run) begin
        cur_v <= 1'b0;
      end else if (tick) begin
        cur   <= pin_s;
        cur_v <= 1'b1;
        fall  <= cur_v & cur & ~pin_s;
      end
    end
  end

  // R5
  fall_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    fall |-> $past(tick) && $past(run));

  // R7
  fall_needs_history_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !cur_v) |=> !fall);

endmodule

// File: rtl/mct_count_regs.sv
module mct_count_regs #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ovf_clr,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              ovf
);
  localparam logic [BYTE_W-1:0] FULL = {BYTE_W{1'b1}};

  logic lo_full;
  logic hi_full;

  assign lo_full = (lo == FULL);
  assign hi_full = (hi == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo  <= '0;
      hi  <= '0;
      ovf <= 1'b0;
    end else begin
      if (lo_wr)    lo <= wr_data;
      else if (inc) lo <= lo + BYTE_W'(1);

      if (hi_wr)              hi <= wr_data;
      else if (inc && lo_full) hi <= hi + BYTE_W'(1);

      if (inc && lo_full && hi_full) ovf <= 1'b1;
      else if (ovf_clr)              ovf <= 1'b0;
    end
  end

  // R8
  lo_write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    lo_wr |=> (lo == $past(wr_data)));

  // R8
  hi_write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    hi_wr |=> (hi == $past(wr_data)));

  // R3
  carry_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && lo_full && !hi_wr) |=> (hi == $past(hi) + BYTE_W'(1)));

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);

endmodule

// File: rtl/mct_timer_unit.sv
module mct_timer_unit
  import mct_pkg::*;
#(
  parameter int DIV         = DEFAULT_DIV,
  parameter int BYTE_W      = DEFAULT_BYTE,
  parameter int SYNC_STAGES = DEFAULT_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              event_mode,
  input  logic              event_pin,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ovf_clr,
  output logic [BYTE_W-1:0] count_lo,
  output logic [BYTE_W-1:0] count_hi,
  output logic              ovf_flag
);
  cnt_mode_e mode;
  logic      tick;
  logic      fall;
  logic      inc;

  assign mode = cnt_mode_e'(event_mode);

  mct_tick_gen #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  mct_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_fall (
    .clk  (clk),
    .rst  (rst),
    .run  (run_en),
    .tick (tick),
    .pin  (event_pin),
    .fall (fall)
  );

  always_comb begin
    unique case (mode)
      MODE_EVENT: inc = run_en & fall;
      default:    inc = run_en & tick;
    endcase
  end

  mct_count_regs #(.BYTE_W(BYTE_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .inc     (inc),
    .lo_wr   (lo_wr),
    .hi_wr   (hi_wr),
    .wr_data (wr_data),
    .ovf_clr (ovf_clr),
    .lo      (count_lo),
    .hi      (count_hi),
    .ovf     (ovf_flag)
  );

  // R7
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !lo_wr && !hi_wr) |=> ($stable(count_lo) && $stable(count_hi)));

  // R9
  event_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (event_mode && !fall && !lo_wr && !hi_wr) |=> ($stable(count_lo) && $stable(count_hi)));

  // R9
  timer_no_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (!event_mode && !tick && !lo_wr && !hi_wr) |=> $stable(count_lo));

endmodule

// File: tb/mct_timer_unit_bench.sv
module mct_timer_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 12;

  logic       clk = 1'b0;
  logic       rst, run_en, event_mode, event_pin, lo_wr, hi_wr, ovf_clr;
  logic [7:0] wr_data;
  logic [7:0] count_lo, count_hi;
  logic       ovf_flag;

  typedef struct {
    logic [15:0] cnt;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  exp_t        mon_item;
  int          checks = 0;
  int          errors = 0;
  int          E = 0;
  logic [15:0] exp_cnt = '0;
  logic        exp_ovf = 1'b0;
  bit          done = 1'b0;

  mct_timer_unit u_mct_timer_unit (
    .clk(clk), .rst(rst), .run_en(run_en), .event_mode(event_mode),
    .event_pin(event_pin), .lo_wr(lo_wr), .hi_wr(hi_wr), .wr_data(wr_data),
    .ovf_clr(ovf_clr), .count_lo(count_lo), .count_hi(count_hi),
    .ovf_flag(ovf_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      E++;
    end
  endtask

  task automatic align(input int ph);
    while ((E % DIV) != ph) step(1);
  endtask

  task automatic expect_now(input string tag);
    exp_t it;
    it.cnt = exp_cnt;
    it.ovf = exp_ovf;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic write_byte(input bit high, input logic [7:0] v);
    if (high) hi_wr = 1'b1; else lo_wr = 1'b1;
    wr_data = v;
    step(1);
    lo_wr = 1'b0;
    hi_wr = 1'b0;
  endtask

  // Monitor: compare every pending expectation just after the falling edge.
  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      mon_item = sb_q.pop_front();
      checks++;
      if ({count_hi, count_lo} !== mon_item.cnt || ovf_flag !== mon_item.ovf) begin
        errors++;
        $display("FAIL %s: actual cnt=%h ovf=%b, expected cnt=%h ovf=%b",
                 mon_item.tag, {count_hi, count_lo}, ovf_flag,
                 mon_item.cnt, mon_item.ovf);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; run_en = 1'b0; event_mode = 1'b0; event_pin = 1'b0;
    lo_wr = 1'b0; hi_wr = 1'b0; ovf_clr = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    E = 0;
    expect_now("R1 reset values");

    // Timer mode stepping
    run_en = 1'b1;
    step(11); expect_now("R2 no step before 12th edge");
    step(1);  exp_cnt = 16'd1; expect_now("R2 first tick");
    step(48); exp_cnt = 16'd5; expect_now("R2 five ticks");

    // Run low freezes
    run_en = 1'b0;
    step(24); expect_now("R7 hold while stopped");
    run_en = 1'b1;

    // Byte loads and wrap
    write_byte(1'b0, 8'hFE);
    write_byte(1'b1, 8'hFF);
    align(11); exp_cnt = 16'hFFFE; expect_now("R8 byte loads");
    step(1);  exp_cnt = 16'hFFFF; expect_now("R2 step to all ones");
    step(12); exp_cnt = 16'h0000; exp_ovf = 1'b1; expect_now("R4 wrap sets flag");
    step(12); exp_cnt = 16'h0001; expect_now("R4 flag sticky");
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    exp_ovf = 1'b0; expect_now("R4 clear");

    // Carry
    write_byte(1'b0, 8'hFF);
    write_byte(1'b1, 8'h12);
    exp_cnt = 16'h12FF; expect_now("R8 load before carry");
    align(11); step(1); exp_cnt = 16'h1300; expect_now("R3 carry into high byte");

    // Write collides with increment
    align(11); write_byte(1'b0, 8'h40);
    exp_cnt = 16'h1340; expect_now("R8 low write wins");
    write_byte(1'b0, 8'hFF);
    align(11); write_byte(1'b1, 8'h20);
    exp_cnt = 16'h2000; expect_now("R8 high write wins, low still steps");

    // Set wins over clear
    write_byte(1'b0, 8'hFF);
    write_byte(1'b1, 8'hFF);
    align(11);
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    exp_cnt = 16'h0000; exp_ovf = 1'b1; expect_now("R4 set beats clear");
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    exp_ovf = 1'b0; expect_now("R4 clear after collision");
    align(0); exp_cnt = 16'h0001;

    // Timer ignores the pin
    event_pin = 1'b1; step(5); event_pin = 1'b0; step(7);
    event_pin = 1'b1; step(6); event_pin = 1'b0; step(6);
    exp_cnt = 16'h0003; expect_now("R9 timer ignores pin");

    // Event mode
    run_en = 1'b0; event_mode = 1'b1;
    write_byte(1'b0, 8'h00);
    write_byte(1'b1, 8'h00);
    exp_cnt = 16'h0000;
    align(0);
    run_en = 1'b1; event_pin = 1'b1; step(12);
    event_pin = 1'b0; step(12);
    expect_now("R5 not yet counted at tick edge");
    step(1); exp_cnt = 16'h0001; expect_now("R5 counted one edge after tick");
    align(0);

    for (int k = 0; k < 3; k++) begin
      event_pin = 1'b1; step(12);
      event_pin = 1'b0; step(12);
    end
    step(1); exp_cnt = 16'h0004; expect_now("R6 one count per 24 clocks");
    align(0);

    step(36); expect_now("R9 steady pin no count");

    step(2); event_pin = 1'b1; step(6); event_pin = 1'b0; step(4);
    step(24); expect_now("R6 short pulse missed");

    // History discarded across a pause
    event_pin = 1'b1; step(12);
    run_en = 1'b0; event_pin = 1'b0; step(24);
    expect_now("R7 hold in event mode");
    run_en = 1'b1; step(12); step(1);
    expect_now("R7 stale sample gives no edge");

    step(2);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule